// File: doc/BRIEF.md
# Hashed Requester-ID to Stream-ID Map

This block keeps a table that translates a 16-bit PCIe requester ID (bus, device and function) into an 8-bit stream-ID offset. Configuration logic fills the table through an insert port. Translation logic then queries it through a lookup port, once per transaction. Both ports turn the ID into a starting slot with a CRC-8 hash. The ID goes into the hash as two bytes, the high byte first.

When the starting slot is taken, the insert port tries the slots that follow, one at a time, and wraps at the end of the table. Each time it passes an entry whose link field is empty, it writes the index it is about to try into that field. A lookup starts at the hashed slot and follows these links until it finds the ID or reaches an entry with no link.

Each stored entry holds three fields: the ID, the stream-ID offset and the link. A clear command empties the whole table. The offset is the given stream ID minus the stream ID of the first insert since the last clear. Only one operation runs at a time, and the `busy` output tells requesters when a new command will be taken.

Top module: `bdf_sid_map`

## Requirements
- R1: After reset, `busy`, `ins_done`, `ins_err`, `lk_hit` and `lk_miss` are 0, `lk_sid` is 0 and the table is empty.
- R2: The start slot is the low IDX_W bits of a CRC-8 with polynomial 0x07, initial value 0 and no reflection, computed over ID[15:8] then ID[7:0]. When an entry sits in its own start slot, its lookup result appears 1 cycle after the request is accepted.
- R3: The stored and returned offset is the insert's stream ID minus the stream ID of the first insert since reset or clear, modulo 256. The first insert therefore stores 0.
- R4: An insert whose slot is occupied moves on to index+1 modulo DEPTH. If the occupied entry's link field is 0, that field is set to index+1 modulo DEPTH, so a link that wraps to index 0 stays 0. The new entry is written with link 0, and `ins_done` pulses for one cycle.
- R5: A lookup follows the links from the start slot. It ends with a one-cycle `lk_hit` pulse, carrying the offset on `lk_sid`, at a non-zero entry whose ID matches. It ends with a one-cycle `lk_miss` pulse at a non-matching entry whose link is 0, or after DEPTH-1 hops. With h hops, the result appears h+1 cycles after the request is accepted. `lk_hit` and `lk_miss` never pulse together.
- R6: An entry whose 32 bits are all 0 is empty. A lookup that lands on an empty entry misses.
- R7: An insert accepted while DEPTH non-zero entries are stored raises `ins_err` together with `ins_done` in the cycle after acceptance, and the table is not changed.
- R8: A clear keeps `busy` high for exactly DEPTH cycles and empties every entry. It also forgets the base stream ID, so every later lookup misses until new inserts arrive.
- R9: Requests are taken only while `busy` is 0, and requests raised while `busy` is 1 are dropped. When several requests arrive in the same cycle, clear is taken first, then insert, then lookup, and the others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_req | input | 1 | Clear the whole table |
| ins_req | input | 1 | Insert request |
| ins_bdf | input | 16 | Requester ID to insert |
| ins_sid | input | 8 | Stream ID to map it to |
| ins_done | output | 1 | One-cycle pulse when an insert ends |
| ins_err | output | 1 | Pulse with ins_done when the table was full |
| lk_req | input | 1 | Lookup request |
| lk_bdf | input | 16 | Requester ID to look up |
| lk_hit | output | 1 | One-cycle pulse: ID found |
| lk_miss | output | 1 | One-cycle pulse: ID not found |
| lk_sid | output | 8 | Offset of the last hit, 0 after a miss |
| busy | output | 1 | An operation is in progress |

## Verification
The bench builds the block with IDX_W = 4, so the table has 16 slots while the hash and the field layout stay the same as in the default build. With only 16 slots, colliding IDs and long probe runs happen all the time. The bench fills the table completely, so a probe that wraps from the last slot to slot 0, and the link lost by that wrap, both occur. Because a full table is in reach, the bench also checks the insert that is rejected when the table is full. After each insert, it checks the hit, the offset and the latency of every stored ID against a model of the table kept in the bench.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CLEAR,
      ST_INSERT,
      ST_LOOKUP
   } bsm_state_e;
endpackage

// File: rtl/bsm_hash.sv
// Bit-serial CRC unrolled over the whole key, most significant bit first,
// which is the same as hashing the key bytes high byte first.
module bsm_hash #(
   parameter int ID_W   = 16,
   parameter int CRC_W  = 8,
   parameter logic [CRC_W-1:0] POLY = 8'h07,
   parameter int IDX_W  = 8
) (
   input  logic [ID_W-1:0]  key,
   output logic [IDX_W-1:0] slot
);
   if (ID_W % 8 != 0) begin : g_bad_id
      $error("bsm_hash: ID_W must be a whole number of bytes");
   end
   if (IDX_W > CRC_W || IDX_W < 1) begin : g_bad_idx
      $error("bsm_hash: IDX_W must lie in 1..CRC_W");
   end

   logic [ID_W:0][CRC_W-1:0] stage;
   assign stage[0] = '0;

   for (genvar g = 0; g < ID_W; g++) begin : g_bit
      logic fb;
      assign fb = stage[g][CRC_W-1] ^ key[ID_W-1-g];
      assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign slot = stage[ID_W][IDX_W-1:0];
endmodule

// File: rtl/bsm_table.sv
// Entry storage: one write port, one combinational read port.
module bsm_table #(
   parameter int ENT_W = 32,
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [ENT_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [ENT_W-1:0] rd_data
);
   localparam int DEPTH = 1 << IDX_W;

   logic [ENT_W-1:0] mem [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[g] <= '0;
         end else if (we && wr_idx == IDX_W'(g)) begin
            mem[g] <= wr_data;
         end
      end
   end

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
   import bsm_pkg::*;
#(
   parameter int ID_W   = 16,
   parameter int SID_W  = 8,
   parameter int NEXT_W = 8,
   parameter int IDX_W  = 8,
   localparam int ENT_W = ID_W + SID_W + NEXT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_req,
   input  logic             ins_req,
   input  logic [ID_W-1:0]  ins_bdf,
   input  logic [SID_W-1:0] ins_sid,
   input  logic             lk_req,
   input  logic [ID_W-1:0]  lk_bdf,
   input  logic [IDX_W-1:0] start_slot,
   input  logic [ENT_W-1:0] rd_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             we,
   output logic [IDX_W-1:0] wr_idx,
   output logic [ENT_W-1:0] wr_data,
   output logic             ins_done,
   output logic             ins_err,
   output logic             lk_hit,
   output logic             lk_miss,
   output logic [SID_W-1:0] lk_sid,
   output logic             busy
);
   localparam int DEPTH = 1 << IDX_W;

   bsm_state_e       state_q;
   logic [IDX_W-1:0] idx_q, hops_q, idx_inc;
   logic [ID_W-1:0]  key_q;
   logic [SID_W-1:0] off_q, base_q, new_off;
   logic             base_vld_q;
   logic [IDX_W:0]   cnt_q;

   logic [ID_W-1:0]   e_bdf;
   logic [SID_W-1:0]  e_sid;
   logic [NEXT_W-1:0] e_nxt;
   logic              e_empty, e_match, full, new_nz, last_hop;

   assign e_bdf    = rd_data[ENT_W-1 -: ID_W];
   assign e_sid    = rd_data[NEXT_W +: SID_W];
   assign e_nxt    = rd_data[NEXT_W-1:0];
   assign e_empty  = (rd_data == '0);
   assign e_match  = !e_empty && (e_bdf == key_q);
   assign idx_inc  = idx_q + IDX_W'(1);
   assign full     = (cnt_q == (IDX_W+1)'(DEPTH));
   assign new_nz   = (key_q != '0) || (off_q != '0);
   assign last_hop = (hops_q == '1);
   assign new_off  = base_vld_q ? (ins_sid - base_q) : '0;
   assign busy     = (state_q != ST_IDLE);
   assign rd_idx   = idx_q;
   assign wr_idx   = idx_q;

   // Write port: clear sweep, new entry, or link patch of an occupied entry
   always_comb begin
      we      = 1'b0;
      wr_data = '0;
      unique case (state_q)
         ST_CLEAR: we = 1'b1;
         ST_INSERT: begin
            if (e_empty) begin
               we      = 1'b1;
               wr_data = {key_q, off_q, NEXT_W'(0)};
            end else if (e_nxt == '0) begin
               we      = 1'b1;
               wr_data = {e_bdf, e_sid, NEXT_W'(idx_inc)};
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         idx_q      <= '0;
         hops_q     <= '0;
         key_q      <= '0;
         off_q      <= '0;
         base_q     <= '0;
         base_vld_q <= 1'b0;
         cnt_q      <= '0;
         ins_done   <= 1'b0;
         ins_err    <= 1'b0;
         lk_hit     <= 1'b0;
         lk_miss    <= 1'b0;
         lk_sid     <= '0;
      end else begin
         ins_done <= 1'b0;
         ins_err  <= 1'b0;
         lk_hit   <= 1'b0;
         lk_miss  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (clr_req) begin
                  state_q    <= ST_CLEAR;
                  idx_q      <= '0;
                  cnt_q      <= '0;
                  base_vld_q <= 1'b0;
               end else if (ins_req) begin
                  if (full) begin
                     ins_done <= 1'b1;
                     ins_err  <= 1'b1;
                  end else begin
                     state_q <= ST_INSERT;
                     idx_q   <= start_slot;
                     key_q   <= ins_bdf;
                     off_q   <= new_off;
                     if (!base_vld_q) begin
                        base_q     <= ins_sid;
                        base_vld_q <= 1'b1;
                     end
                  end
               end else if (lk_req) begin
                  state_q <= ST_LOOKUP;
                  idx_q   <= start_slot;
                  key_q   <= lk_bdf;
                  hops_q  <= '0;
               end
            end
            ST_CLEAR: begin
               idx_q <= idx_inc;
               if (idx_q == '1) state_q <= ST_IDLE;
            end
            ST_INSERT: begin
               if (e_empty) begin
                  state_q  <= ST_IDLE;
                  ins_done <= 1'b1;
                  if (new_nz) cnt_q <= cnt_q + 1'b1;
               end else begin
                  idx_q <= idx_inc;
               end
            end
            ST_LOOKUP: begin
               if (e_match) begin
                  state_q <= ST_IDLE;
                  lk_hit  <= 1'b1;
                  lk_sid  <= e_sid;
               end else if (e_nxt == '0 || last_hop) begin
                  state_q <= ST_IDLE;
                  lk_miss <= 1'b1;
                  lk_sid  <= '0;
               end else begin
                  idx_q  <= e_nxt[IDX_W-1:0];
                  hops_q <= hops_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lk_hit, lk_miss})); // R5
   AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit || lk_miss) |=> !(lk_hit || lk_miss)); // R5
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ins_err |-> ins_done); // R7
   AST_NO_PROBE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_INSERT) |-> !full); // R7
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= (IDX_W+1)'(DEPTH)); // R7
   AST_CLEAR_ENDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CLEAR && idx_q == '1) |=> (cnt_q == '0 && !base_vld_q && !busy)); // R8
   AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_done && !ins_err) |-> $past(busy)); // R9
endmodule

// File: rtl/bdf_sid_map.sv
module bdf_sid_map #(
   parameter int ID_W   = 16,
   parameter int SID_W  = 8,
   parameter int NEXT_W = 8,
   parameter int IDX_W  = 8,
   parameter logic [7:0] POLY = 8'h07
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_req,
   input  logic             ins_req,
   input  logic [ID_W-1:0]  ins_bdf,
   input  logic [SID_W-1:0] ins_sid,
   output logic             ins_done,
   output logic             ins_err,
   input  logic             lk_req,
   input  logic [ID_W-1:0]  lk_bdf,
   output logic             lk_hit,
   output logic             lk_miss,
   output logic [SID_W-1:0] lk_sid,
   output logic             busy
);
   localparam int ENT_W = ID_W + SID_W + NEXT_W;

   if (IDX_W > NEXT_W) begin : g_bad_next
      $error("bdf_sid_map: link field narrower than the slot index");
   end

   logic [ID_W-1:0]  hash_key;
   logic [IDX_W-1:0] start_slot, rd_idx, wr_idx;
   logic [ENT_W-1:0] rd_data, wr_data;
   logic             we;

   // one hash shared by both ports; insert outranks lookup
   assign hash_key = ins_req ? ins_bdf : lk_bdf;

   bsm_hash #(.ID_W(ID_W), .CRC_W(8), .POLY(POLY), .IDX_W(IDX_W)) i_hash (
      .key  (hash_key),
      .slot (start_slot)
   );

   bsm_table #(.ENT_W(ENT_W), .IDX_W(IDX_W)) i_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   bsm_ctrl #(.ID_W(ID_W), .SID_W(SID_W), .NEXT_W(NEXT_W), .IDX_W(IDX_W)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_req    (clr_req),
      .ins_req    (ins_req),
      .ins_bdf    (ins_bdf),
      .ins_sid    (ins_sid),
      .lk_req     (lk_req),
      .lk_bdf     (lk_bdf),
      .start_slot (start_slot),
      .rd_data    (rd_data),
      .rd_idx     (rd_idx),
      .we         (we),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .ins_done   (ins_done),
      .ins_err    (ins_err),
      .lk_hit     (lk_hit),
      .lk_miss    (lk_miss),
      .lk_sid     (lk_sid),
      .busy       (busy)
   );
endmodule

// File: tb/test_bdf_sid_map.sv
`timescale 1ns/1ps
module test_bdf_sid_map;
   localparam int BIDX = 4;
   localparam int BDEP = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr_req = 1'b0, ins_req = 1'b0, lk_req = 1'b0;
   logic [15:0] ins_bdf = '0, lk_bdf = '0;
   logic [7:0]  ins_sid = '0;
   logic        ins_done, ins_err, lk_hit, lk_miss, busy;
   logic [7:0]  lk_sid;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   bdf_sid_map #(.IDX_W(BIDX)) i_bdf_sid_map (
      .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .ins_req(ins_req),
      .ins_bdf(ins_bdf), .ins_sid(ins_sid), .ins_done(ins_done), .ins_err(ins_err),
      .lk_req(lk_req), .lk_bdf(lk_bdf), .lk_hit(lk_hit), .lk_miss(lk_miss),
      .lk_sid(lk_sid), .busy(busy)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_tab [BDEP];
   int          m_cnt;
   logic [7:0]  m_base;
   bit          m_base_vld;

   function automatic logic [7:0] crc8(input logic [15:0] id);
      logic [7:0] c = 8'h00;
      for (int b = 0; b < 2; b++) begin
         c = c ^ (b == 0 ? id[15:8] : id[7:0]);
         for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

   task automatic m_clear();
      for (int i = 0; i < BDEP; i++) m_tab[i] = '0;
      m_cnt = 0;
      m_base_vld = 0;
   endtask

   task automatic m_insert(input logic [15:0] bdf, input logic [7:0] sid, output bit err);
      int i;
      logic [7:0] off;
      err = (m_cnt == BDEP);
      if (err) return;
      if (!m_base_vld) begin m_base = sid; m_base_vld = 1; end
      off = sid - m_base;
      i = int'(crc8(bdf)) % BDEP;
      while (m_tab[i] != 0) begin
         if (m_tab[i][7:0] == 0) m_tab[i][7:0] = 8'((i + 1) % BDEP);
         i = (i + 1) % BDEP;
      end
      m_tab[i] = {bdf, off, 8'h00};
      if (m_tab[i] != 0) m_cnt++;
   endtask

   task automatic m_lookup(input logic [15:0] bdf, output bit hit, output logic [7:0] sid,
                           output int hops);
      int i = int'(crc8(bdf)) % BDEP;
      hops = 0;
      forever begin
         if (m_tab[i] != 0 && m_tab[i][31:16] == bdf) begin
            hit = 1; sid = m_tab[i][15:8]; return;
         end
         if (m_tab[i][7:0] == 0 || hops == BDEP - 1) begin
            hit = 0; sid = 0; return;
         end
         i = int'(m_tab[i][7:0]);
         hops++;
      end
   endtask

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic do_insert(input logic [15:0] bdf, input logic [7:0] sid);
      bit exp_err;
      int n = 0;
      m_insert(bdf, sid, exp_err);
      wait_idle();
      ins_bdf = bdf; ins_sid = sid; ins_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ins_req = 1'b0;
      while (!ins_done && n < 64) begin @(negedge clk); n++; end
      chk(ins_done, "R4 insert done", 32'(ins_done), 1);
      chk(ins_err == exp_err, "R7 insert error flag", 32'(ins_err), 32'(exp_err));
      @(negedge clk);
      chk(!ins_done, "R4 done is one pulse", 32'(ins_done), 0);
   endtask

   task automatic do_lookup(input logic [15:0] bdf, input string tag);
      bit exp_hit;
      logic [7:0] exp_sid;
      int exp_hops, cnt = 0;
      m_lookup(bdf, exp_hit, exp_sid, exp_hops);
      wait_idle();
      lk_bdf = bdf; lk_req = 1'b1;
      @(posedge clk);
      do begin
         @(negedge clk);
         lk_req = 1'b0;
         cnt++;
      end while (!(lk_hit || lk_miss) && cnt < 64);
      chk(lk_hit == exp_hit && lk_miss == !exp_hit, {tag, " hit/miss"},
          32'({lk_hit, lk_miss}), 32'({exp_hit, !exp_hit}));
      chk(lk_sid == exp_sid, "R3 returned offset", 32'(lk_sid), 32'(exp_sid));
      chk(cnt - 1 == exp_hops + 1, exp_hops == 0 ? "R2 latency" : "R4 probe latency",
          32'(cnt - 1), 32'(exp_hops + 1));
   endtask

   function automatic logic [15:0] id_of(input int k);
      return 16'h1000 + 16'(k) * 16'h0137;
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      #1500000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int nb;
      bit spurious;
      m_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !ins_done && !ins_err, "R1 control outputs", 32'({busy, ins_done, ins_err}), 0);
      chk(!lk_hit && !lk_miss && lk_sid == 0, "R1 lookup outputs", 32'({lk_hit, lk_miss, lk_sid}), 0);

      // R6 empty table
      do_lookup(16'h0100, "R6 empty table");
      do_lookup(16'hbeef, "R6 empty table");

      // R2 R3 R4 R5: fill the table, checking every stored ID after each insert
      for (int k = 0; k < BDEP; k++) begin
         do_insert(id_of(k), 8'h40 + 8'(3 * k));
         for (int j = 0; j <= k; j++) do_lookup(id_of(j), "R5 stored id");
      end
      for (int k = 0; k < 6; k++) do_lookup(16'h7000 + 16'(k * 17), "R5 absent id");

      // R7 full table rejects and keeps contents
      do_insert(16'h5555, 8'h11);
      for (int j = 0; j < BDEP; j++) do_lookup(id_of(j), "R7 unchanged table");
      do_lookup(16'h5555, "R7 rejected id");

      // R9 R8: simultaneous requests, clear wins; lookup during clear dropped
      wait_idle();
      clr_req = 1'b1; ins_req = 1'b1; ins_bdf = 16'h6666; ins_sid = 8'h22;
      lk_req = 1'b1; lk_bdf = id_of(0);
      @(posedge clk);
      @(negedge clk);
      clr_req = 1'b0; ins_req = 1'b0; lk_req = 1'b0;
      m_clear();
      nb = 0; spurious = 0;
      while (busy && nb < 64) begin
         if (lk_hit || lk_miss || ins_done) spurious = 1;
         if (nb == 4) lk_req = 1'b1;
         else lk_req = 1'b0;
         nb++;
         @(negedge clk);
      end
      lk_req = 1'b0;
      chk(nb == BDEP, "R8 clear length", 32'(nb), 32'(BDEP));
      repeat (4) begin
         if (lk_hit || lk_miss || ins_done) spurious = 1;
         @(negedge clk);
      end
      chk(!spurious, "R9 requests while busy dropped", 32'(spurious), 0);
      for (int j = 0; j < BDEP; j++) do_lookup(id_of(j), "R8 cleared table");
      do_lookup(16'h6666, "R9 losing insert dropped");

      // R3 new base after clear, with wrap-around subtraction
      do_insert(16'h2222, 8'h90);
      do_insert(16'h3333, 8'h95);
      do_insert(16'h4444, 8'h10);
      do_lookup(16'h2222, "R3 first insert");
      do_lookup(16'h3333, "R3 positive offset");
      do_lookup(16'h4444, "R3 wrapped offset");

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule